// File: doc/BRIEF.md
# Three-Wire Serial Configuration Loader

This block receives 32-bit configuration words from an external controller over a three-wire link: a serial clock, a serial data line and a latch strobe. All three pins are asynchronous to the chip. They are sampled by a faster system clock through two-flop synchronizers, and rising edges of the serial clock are found in the system-clock domain. Every serial clock rising edge shifts one data bit into a holding register, most-significant bit first.

A rising edge of the latch strobe ends a word. If exactly 32 bits arrived since the previous latch, the three least-significant bits of the word select a destination, and the whole word is copied into that configuration register. Any other bit count discards the word and sets a sticky framing error. The block also watches the serial timing. A serial clock phase or a latch pulse that is shorter than its configured minimum, counted in system clock cycles, sets a sticky timing error.

From the stored registers the block extracts an integer divide value, a fractional numerator and a fractional modulus. It also raises an integer-mode flag for downstream divider logic.

Top module: `tw_loader`

## Requirements
- R1: Each serial clock rising edge, as seen after synchronization, shifts the synchronized data bit into the holding register. A word is sent most-significant bit first, so the first bit sent ends up in bit 31.
- R2: When a word is committed, its bits 2..0 give the destination code. Codes 0 to NUM_REGS-1 (0 to 5 by default) write the full 32-bit word into configuration register `cfgRegs[code]`.
- R3: A configuration register changes only on a rising edge of the latch strobe that follows exactly 32 serial clock rising edges counted since the previous latch rising edge. Shifting alone changes no register.
- R4: A latch rising edge after any bit count other than 32 (fewer or more) discards the word and sets `countErr`. `countErr` stays set until reset.
- R5: A committed word whose code is 6 or 7 (NUM_REGS or above) changes no register and raises no error.
- R6: `intVal` is bits 18..3 of register 0. `fracVal` is bits 30..19 of register 0. `modVal` is bits 14..3 of register 1.
- R7: `intMode` is 1 exactly when `fracVal` is 0 and bit 8 of register 2 (the lock-detect-function bit) is 1.
- R8: A serial clock high or low phase that lasts fewer than MIN_PHASE system cycles (3 by default) sets `timingErr`, and it stays set until reset. A phase of exactly MIN_PHASE cycles is legal. A timing error does not stop the word from being processed.
- R9: A latch high pulse of fewer than MIN_LATCH system cycles (2 by default) sets `timingErr`. A pulse of exactly MIN_LATCH cycles is legal.
- R10: After reset every configuration register is 0, both error flags are 0 and `intMode` is 0.
- R11: Each pin passes through two synchronizer flops and one edge-detect flop. A latch that commits a word therefore updates the register on the third system clock edge after the pin rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| serClk | input | 1 | Serial clock pin, asynchronous |
| serData | input | 1 | Serial data pin, asynchronous |
| serLatch | input | 1 | Latch strobe pin, asynchronous |
| cfgRegs | output | NUM_REGS x 32 | Configuration register file |
| intVal | output | 16 | Integer divide field |
| fracVal | output | 12 | Fractional numerator field |
| modVal | output | 12 | Fractional modulus field |
| intMode | output | 1 | Integer-mode flag |
| countErr | output | 1 | Sticky framing error (wrong bit count) |
| timingErr | output | 1 | Sticky minimum-timing error |

## Verification
The bench sends words of 31 and 33 bits. A design that committed on any count, or that let its counter wrap, would overwrite a register and leave `countErr` clear. It writes to codes 6 and 7, which catches a decoder that folds unused codes onto real registers. It also holds a complete word before the latch is raised, which catches a design that commits on the 32nd edge. Clock phases and latch pulses are driven one cycle below their minimum and exactly at it. An off-by-one in the phase counters would show up as a missing error or as a false one. The latch-to-register delay is measured cycle by cycle, which catches a lost or an extra synchronizer stage.

// File: rtl/tw_loader_pkg.sv
package tw_loader_pkg;
  localparam int WORD_W   = 32;
  localparam int ADDR_W   = 3;
  localparam int CNT_W    = 6;
  localparam int INT_LSB  = 3;
  localparam int INT_W    = 16;
  localparam int FRAC_LSB = 19;
  localparam int FRAC_W   = 12;
  localparam int MOD_LSB  = 3;
  localparam int MOD_W    = 12;
  localparam int LDF_REG  = 2;
  localparam int LDF_BIT  = 8;

  typedef struct packed {
    logic shift;
    logic commit;
    logic countErrSet;
    logic timingErrSet;
  } strobe_t;
endpackage

// File: rtl/tw_sync.sv
module tw_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], din[i]};
    end
    assign dout[i] = chain[STAGES-1];
  end
endmodule

// File: rtl/tw_ctrl.sv
module tw_ctrl
  import tw_loader_pkg::*;
#(
  parameter int MIN_PHASE = 3,
  parameter int MIN_LATCH = 2
) (
  input  logic    clk,
  input  logic    rst_n,
  input  logic    clkS,
  input  logic    leS,
  output strobe_t st
);
  localparam int PH_W = $clog2(MIN_PHASE + 1);
  localparam int LE_W = $clog2(MIN_LATCH + 1);
  localparam logic [PH_W-1:0]  PH_MAX   = PH_W'(MIN_PHASE);
  localparam logic [PH_W-1:0]  PH_LIMIT = PH_W'(MIN_PHASE - 1);
  localparam logic [LE_W-1:0]  LE_MAX   = LE_W'(MIN_LATCH);
  localparam logic [LE_W-1:0]  LE_LIMIT = LE_W'(MIN_LATCH - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);

  logic clkPrev, lePrev;
  logic clkRise, clkChg, leRise, leFall, leChg;
  logic [PH_W-1:0]  phaseCnt;
  logic [LE_W-1:0]  leCnt;
  logic [CNT_W-1:0] bitCount;

  assign clkRise = clkS & ~clkPrev;
  assign clkChg  = clkS ^ clkPrev;
  assign leRise  = leS & ~lePrev;
  assign leFall  = ~leS & lePrev;
  assign leChg   = leS ^ lePrev;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clkPrev  <= 1'b0;
      lePrev   <= 1'b0;
      phaseCnt <= PH_MAX;
      leCnt    <= LE_MAX;
      bitCount <= '0;
    end else begin
      clkPrev <= clkS;
      lePrev  <= leS;
      if (clkChg)                phaseCnt <= '0;
      else if (phaseCnt != PH_MAX) phaseCnt <= phaseCnt + 1'b1;
      if (leChg)                 leCnt <= '0;
      else if (leCnt != LE_MAX)  leCnt <= leCnt + 1'b1;
      if (leRise)                                bitCount <= '0;
      else if (clkRise && bitCount != CNT_MAX)   bitCount <= bitCount + 1'b1;
    end
  end

  always_comb begin
    st.shift        = clkRise;
    st.commit       = leRise && (bitCount == CNT_FULL);
    st.countErrSet  = leRise && (bitCount != CNT_FULL);
    st.timingErrSet = (clkChg && (phaseCnt < PH_LIMIT)) ||
                      (leFall && (leCnt < LE_LIMIT));
  end

  // R3: the bit count restarts after every latch edge
  assert_count_clear_R3: assert property (@(posedge clk) disable iff (!rst_n)
    leRise |=> bitCount == '0);

  // R1: each serial clock edge advances the count by exactly one
  assert_count_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (clkRise && !leRise && bitCount != CNT_MAX) |=> bitCount == $past(bitCount) + 1'b1);
endmodule

// File: rtl/tw_datapath.sv
module tw_datapath
  import tw_loader_pkg::*;
#(
  parameter int NUM_REGS = 6
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  strobe_t                        st,
  input  logic                           dataBit,
  output logic [NUM_REGS-1:0][WORD_W-1:0] cfgRegs,
  output logic [INT_W-1:0]               intVal,
  output logic [FRAC_W-1:0]              fracVal,
  output logic [MOD_W-1:0]               modVal,
  output logic                           intMode,
  output logic                           countErr,
  output logic                           timingErr
);
  logic [WORD_W-1:0] shiftReg;
  logic [ADDR_W-1:0] dest;
  logic              destOk;

  assign dest   = shiftReg[ADDR_W-1:0];
  assign destOk = int'(dest) < NUM_REGS;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      shiftReg  <= '0;
      countErr  <= 1'b0;
      timingErr <= 1'b0;
    end else begin
      if (st.shift)        shiftReg  <= {shiftReg[WORD_W-2:0], dataBit};
      if (st.countErrSet)  countErr  <= 1'b1;
      if (st.timingErrSet) timingErr <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic [WORD_W-1:0] word;
    always_ff @(posedge clk) begin
      if (!rst_n)                                           word <= '0;
      else if (st.commit && destOk && dest == ADDR_W'(i))   word <= shiftReg;
    end
    assign cfgRegs[i] = word;
  end

  assign intVal  = cfgRegs[0][INT_LSB +: INT_W];
  assign fracVal = cfgRegs[0][FRAC_LSB +: FRAC_W];
  assign modVal  = cfgRegs[1][MOD_LSB +: MOD_W];
  assign intMode = (fracVal == '0) && cfgRegs[LDF_REG][LDF_BIT];

  // R3: no commit strobe, no register change
  assert_regs_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !st.commit |=> $stable(cfgRegs));

  // R5: unused destination codes leave the file untouched
  assert_unused_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st.commit && !destOk) |=> $stable(cfgRegs));

  // R4: framing error is sticky
  assert_sticky_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
    countErr |=> countErr);

  // R8: timing error is sticky
  assert_sticky_timing_R8: assert property (@(posedge clk) disable iff (!rst_n)
    timingErr |=> timingErr);
endmodule

// File: rtl/tw_loader.sv
module tw_loader
  import tw_loader_pkg::*;
#(
  parameter int NUM_REGS    = 6,
  parameter int MIN_PHASE   = 3,
  parameter int MIN_LATCH   = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            serClk,
  input  logic                            serData,
  input  logic                            serLatch,
  output logic [NUM_REGS-1:0][WORD_W-1:0] cfgRegs,
  output logic [INT_W-1:0]                intVal,
  output logic [FRAC_W-1:0]               fracVal,
  output logic [MOD_W-1:0]                modVal,
  output logic                            intMode,
  output logic                            countErr,
  output logic                            timingErr
);
  logic [2:0] pinsSync;
  strobe_t    st;

  tw_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .din  ({serClk, serData, serLatch}),
    .dout (pinsSync)
  );

  tw_ctrl #(.MIN_PHASE(MIN_PHASE), .MIN_LATCH(MIN_LATCH)) u_ctrl (
    .clk  (clk),
    .rst_n(rst_n),
    .clkS (pinsSync[2]),
    .leS  (pinsSync[0]),
    .st   (st)
  );

  tw_datapath #(.NUM_REGS(NUM_REGS)) u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .st       (st),
    .dataBit  (pinsSync[1]),
    .cfgRegs  (cfgRegs),
    .intVal   (intVal),
    .fracVal  (fracVal),
    .modVal   (modVal),
    .intMode  (intMode),
    .countErr (countErr),
    .timingErr(timingErr)
  );
endmodule

// File: tb/tb_tw_loader.sv
module tb_tw_loader;
  localparam int NR = 6;
  localparam int MINPH = 3;
  localparam int MINLE = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pinClk = 1'b0, pinData = 1'b0, pinLe = 1'b0;
  logic [NR-1:0][31:0] cfgRegs;
  logic [15:0] intVal;
  logic [11:0] fracVal, modVal;
  logic intMode, countErr, timingErr;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  tw_loader #(.NUM_REGS(NR), .MIN_PHASE(MINPH), .MIN_LATCH(MINLE)) dut (
    .clk(clk), .rst_n(rst_n), .serClk(pinClk), .serData(pinData), .serLatch(pinLe),
    .cfgRegs(cfgRegs), .intVal(intVal), .fracVal(fracVal), .modVal(modVal),
    .intMode(intMode), .countErr(countErr), .timingErr(timingErr));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  logic [2:0] sampleQ[$];
  bit [31:0] mRegs [NR];
  bit [31:0] mShift;
  int mCnt, runClk, runLe;
  bit mCntErr, mTimErr, mPrevClk, mPrevLe;

  task automatic modelReset();
    sampleQ.delete();
    foreach (mRegs[i]) mRegs[i] = 0;
    mShift = 0; mCnt = 0; runClk = 1000; runLe = 1000;
    mCntErr = 0; mTimErr = 0; mPrevClk = 0; mPrevLe = 0;
  endtask

  task automatic modelStep(input logic [2:0] s);
    bit c = s[2], d = s[1], l = s[0];
    bit cRise = c && !mPrevClk;
    bit lRise = l && !mPrevLe;
    bit lFall = !l && mPrevLe;
    if (c != mPrevClk) begin
      if (runClk < MINPH) mTimErr = 1;
      runClk = 1;
    end else if (runClk < 1000) runClk++;
    if (l != mPrevLe) begin
      if (lFall && runLe < MINLE) mTimErr = 1;
      runLe = 1;
    end else if (runLe < 1000) runLe++;
    if (lRise) begin
      if (mCnt == 32) begin
        if (int'(mShift[2:0]) < NR) mRegs[mShift[2:0]] = mShift;
      end else mCntErr = 1;
      mCnt = 0;
    end
    if (cRise) begin
      mShift = {mShift[30:0], d};
      if (!lRise && mCnt < 63) mCnt++;
    end
    mPrevClk = c; mPrevLe = l;
  endtask

  always @(posedge clk) begin
    if (!rst_n) modelReset();
    else begin
      sampleQ.push_back({pinClk, pinData, pinLe});
      if (sampleQ.size() > 2) modelStep(sampleQ.pop_front());
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      for (int i = 0; i < NR; i++) check(cfgRegs[i] == mRegs[i], "R2 register file", cfgRegs[i], mRegs[i]);
      check(intVal == mRegs[0][18:3], "R6 intVal", 32'(intVal), 32'(mRegs[0][18:3]));
      check(fracVal == mRegs[0][30:19], "R6 fracVal", 32'(fracVal), 32'(mRegs[0][30:19]));
      check(modVal == mRegs[1][14:3], "R6 modVal", 32'(modVal), 32'(mRegs[1][14:3]));
      check(intMode == (mRegs[0][30:19] == 0 && mRegs[2][8]), "R7 intMode", 32'(intMode),
            32'(mRegs[0][30:19] == 0 && mRegs[2][8]));
      check(countErr == mCntErr, "R4 countErr", 32'(countErr), 32'(mCntErr));
      check(timingErr == mTimErr, "R8 timingErr", 32'(timingErr), 32'(mTimErr));
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic doReset();
    rst_n = 1'b0; pinClk = 0; pinData = 0; pinLe = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  task automatic sendBits(input logic [31:0] w, input int nbits, input int hi, input int lo);
    for (int b = nbits - 1; b >= 0; b--) begin
      pinData = (b < 32) ? w[b] : 1'b0;
      pinClk = 1'b0;
      repeat (lo) @(negedge clk);
      pinClk = 1'b1;
      repeat (hi) @(negedge clk);
    end
    pinClk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic latch(input int width);
    pinLe = 1'b1;
    repeat (width) @(negedge clk);
    pinLe = 1'b0;
    repeat (6) @(negedge clk);
  endtask

  task automatic writeWord(input logic [31:0] w);
    sendBits(w, 32, 4, 4);
    latch(3);
  endtask

  function automatic logic [31:0] mkR0(input int iv, input int fv);
    return (32'(fv) << 19) | (32'(iv) << 3);
  endfunction

  // ---------------- scenarios ----------------
  initial begin
    logic [NR-1:0][31:0] snap;
    logic [31:0] w;
    doReset();

    // R10: reset state
    for (int i = 0; i < NR; i++) check(cfgRegs[i] == 0, "R10 reset register", cfgRegs[i], 0);
    check(!countErr && !timingErr, "R10 reset errors", {30'b0, countErr, timingErr}, 0);
    check(!intMode, "R10 reset intMode", 32'(intMode), 0);

    // R1/R6: integer field, MSB-first order
    w = mkR0(1234, 0);
    writeWord(w);
    check(cfgRegs[0] == w, "R1 word order", cfgRegs[0], w);
    check(intVal == 16'd1234, "R6 intVal decode", 32'(intVal), 1234);

    // R11: latency of the commit, modulus in register 1
    w = (32'd1000 << 3) | 32'd1;
    sendBits(w, 32, 4, 4);
    pinLe = 1'b1;
    @(negedge clk); check(cfgRegs[1] == 0, "R11 not yet after 1", cfgRegs[1], 0);
    @(negedge clk); check(cfgRegs[1] == 0, "R11 not yet after 2", cfgRegs[1], 0);
    @(negedge clk); check(cfgRegs[1] == w, "R11 updated after 3", cfgRegs[1], w);
    pinLe = 1'b0;
    repeat (6) @(negedge clk);
    check(modVal == 12'd1000, "R6 modVal decode", 32'(modVal), 1000);

    // R7: integer mode with lock-detect-function bit
    writeWord((32'd1 << 8) | 32'd2);
    check(intMode == 1'b1, "R7 intMode set", 32'(intMode), 1);
    writeWord(mkR0(200, 5));
    check(intMode == 1'b0, "R7 intMode clear on FRAC", 32'(intMode), 0);
    check(fracVal == 12'd5, "R6 fracVal decode", 32'(fracVal), 5);

    // R3: full word shifted but not latched
    w = 32'hA5A5_0003;
    sendBits(w, 32, 4, 4);
    repeat (8) @(negedge clk);
    check(cfgRegs[3] == 0, "R3 no commit before latch", cfgRegs[3], 0);
    latch(3);
    check(cfgRegs[3] == w, "R3 commit on latch", cfgRegs[3], w);

    // R2: every code writes its own register
    for (int i = 0; i < NR; i++) writeWord({8'h5A, 8'(i), 13'h1234, 3'(i)});
    for (int i = 0; i < NR; i++)
      check(cfgRegs[i] == {8'h5A, 8'(i), 13'h1234, 3'(i)}, "R2 code select", cfgRegs[i],
            {8'h5A, 8'(i), 13'h1234, 3'(i)});

    // R5: unused codes
    snap = cfgRegs;
    writeWord(32'hFFFF_FFFE);
    writeWord(32'hFFFF_FFFF);
    check(cfgRegs == snap, "R5 unused code ignored", cfgRegs[0], snap[0]);
    check(!countErr, "R5 no error on unused code", 32'(countErr), 0);

    // R4: short word
    snap = cfgRegs;
    sendBits(32'h0000_0000, 31, 4, 4);
    latch(3);
    check(countErr, "R4 short word error", 32'(countErr), 1);
    check(cfgRegs == snap, "R4 short word discarded", cfgRegs[0], snap[0]);
    writeWord(mkR0(77, 0));
    check(countErr, "R4 sticky", 32'(countErr), 1);
    check(intVal == 16'd77, "R4 next good word accepted", 32'(intVal), 77);

    // R4: long word
    doReset();
    check(!countErr, "R10 reset clears error", 32'(countErr), 0);
    sendBits(mkR0(99, 0), 33, 4, 4);
    latch(3);
    check(countErr, "R4 long word error", 32'(countErr), 1);
    check(cfgRegs[0] == 0, "R4 long word discarded", cfgRegs[0], 0);

    // R8: phase boundaries
    doReset();
    sendBits(mkR0(5, 0), 32, MINPH, MINPH);
    latch(3);
    check(!timingErr, "R8 minimum phase legal", 32'(timingErr), 0);
    check(intVal == 16'd5, "R8 legal word stored", 32'(intVal), 5);
    sendBits(mkR0(6, 0), 32, MINPH - 1, 4);
    latch(3);
    check(timingErr, "R8 short high phase", 32'(timingErr), 1);
    check(intVal == 16'd6, "R8 word still processed", 32'(intVal), 6);
    doReset();
    sendBits(mkR0(7, 0), 32, 4, MINPH - 1);
    latch(3);
    check(timingErr, "R8 short low phase", 32'(timingErr), 1);

    // R9: latch width
    doReset();
    sendBits(mkR0(8, 0), 32, 4, 4);
    latch(MINLE);
    check(!timingErr, "R9 minimum latch legal", 32'(timingErr), 0);
    sendBits(mkR0(9, 0), 32, 4, 4);
    latch(MINLE - 1);
    check(timingErr, "R9 short latch", 32'(timingErr), 1);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; failures++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'd1, 32'd0);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule